// File: doc/BRIEF.md
# Triplet Spike-Timing Code Generator

The block watches two single-cycle strobes, one from the neuron before the synapse (pre) and one from the neuron after it (post). It measures the gaps between them on a shared time base and turns each completed spike pattern into a 6-bit drive code. The code comes from a rewritable 128-entry table. A post spike that follows a pre spike, or a post–pre–post triplet, is a strengthening (potentiation) event. A pre spike that follows a post spike is a weakening (depression) event.

Two saturating counters count time-base ticks. The first-gap counter restarts on every spike and the post-to-post counter restarts on every post spike. The first gap is quantised to 4 bits and the post-to-post gap to 2 bits. Together with the event sign they form a 7-bit table index: bit 6 is 1 for depression, bits 5:2 hold the first-gap bin and bits 1:0 hold the post-to-post bin. Software fills the table through a synchronous write port, so any timing can map to any code.

A control state machine has four states. ST_IDLE waits for a spike. ST_PRE means a pre spike was seen with no open post. ST_POST means a post spike was seen. ST_TRIP (triplet mode only) means a post spike was followed by a pre spike, and the block now waits for the closing post.

Transitions:
- ST_IDLE goes to ST_PRE on a lone pre spike and to ST_POST on a lone post spike. Simultaneous pre and post spikes emit at once and stay in ST_IDLE.
- ST_PRE returns to ST_IDLE when a post spike emits.
- ST_POST emits a depression on a lone pre spike and moves to ST_TRIP in triplet mode or ST_IDLE in pair mode. On simultaneous spikes it emits a potentiation and returns to ST_IDLE.
- ST_TRIP returns to ST_IDLE when a post spike emits.
- A repeated spike of the waiting kind keeps the current state and restarts the timing.

Top module: `spike_interval_coder`

## Requirements
- R1: After reset, code_vld is 0, code is 0 and every table entry is 0, so an event before any table write emits code 0.
- R2: A post spike closing an open pre (ST_PRE) emits code_pot=1 with index {0, first-gap bin, post bin}. The post bin is 0 in pair mode (trip_mode=0) and 3 in triplet mode, because no earlier post exists.
- R3: A lone pre spike while a post is open emits code_pot=0 with index {1, first-gap bin, 00}. In pair mode the block then returns to idle, so a later post emits nothing.
- R4: In triplet mode, post–pre–post emits the depression of R3 at the pre spike. At the second post it emits code_pot=1 with index {0, bin of the pre-to-post gap, bin of the post-to-post gap}.
- R5: A gap equals the number of clock edges with tick=1 strictly between the start spike edge and the stop spike edge. Edges with tick=0 do not count.
- R6: The first-gap bin is min(gap>>2, 15) and the post bin is min(gap>>6, 3).
- R7: Each counter stops at its maximum (1023) and never wraps, so a very long gap indexes the last bin.
- R8: Pre and post spikes in the same cycle form a zero first gap on the potentiation side. In ST_POST with triplet mode the post bin comes from the measured post-to-post gap.
- R9: A further spike of the kind that opened the wait restarts the measurement, so the latest pre (or post) is the one timed.
- R10: A table write takes effect at the clock edge. The code is read at the event edge and shown with a code_vld pulse exactly one cycle long, in the cycle after the spike was sampled.
- R11: Cycles with no spike produce no code_vld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Time-base enable for the gap counters |
| pre_spk | input | 1 | Pre-synaptic spike strobe |
| post_spk | input | 1 | Post-synaptic spike strobe |
| trip_mode | input | 1 | 1 = triplet operation, 0 = pair only |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 7 | Table write index |
| tbl_data | input | 6 | Table write code |
| code_vld | output | 1 | One-cycle event strobe |
| code | output | 6 | Drive code from the table |
| code_pot | output | 1 | 1 = potentiation, 0 = depression |

## Verification
In pair mode, pre-then-post and post-then-pre patterns with several gap lengths check the sign bit and the first-gap bins. A post following a depression then shows that pair mode does not carry on into a triplet. Triplet patterns with short and long gaps check that both bins come from different start spikes, and a pre-first pattern in triplet mode checks the forced last post bin. Coincident spikes, restarted waits, stretches with the time base held low, and a gap longer than the counter range separate zero-gap handling, latest-spike timing, tick gating and saturation from wrapping. A table rewrite followed by a matching event shows that the write took effect.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int Q1_W   = 4;
    localparam int Q2_W   = 2;
    localparam int IDX_W  = 1 + Q1_W + Q2_W;
    localparam int CODE_W = 6;

    typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_POST, ST_TRIP} sic_state_e;
    typedef enum logic [1:0] {Q2_ZERO, Q2_MEAS, Q2_LAST} sic_q2sel_e;
endpackage

// File: rtl/sic_sat_counter.sv
module sic_sat_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick && cnt != TOP)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sic_quant.sv
module sic_quant #(
    parameter int IN_W  = 10,
    parameter int SHIFT = 2,
    parameter int OUT_W = 4
) (
    input  logic [IN_W-1:0]  val,
    output logic [OUT_W-1:0] bin
);
    localparam logic [IN_W-1:0] LAST = IN_W'((1 << OUT_W) - 1);
    logic [IN_W-1:0] shifted;

    assign shifted = val >> SHIFT;
    assign bin     = (shifted > LAST) ? '1 : shifted[OUT_W-1:0];
endmodule

// File: rtl/sic_code_table.sv
module sic_code_table #(
    parameter int IDX_W  = 7,
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [CODE_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [CODE_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;
    logic [CODE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spike_interval_coder.sv
module spike_interval_coder
    import sic_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int Q1_SHIFT = 2,
    parameter int Q2_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pre_spk,
    input  logic              post_spk,
    input  logic              trip_mode,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_addr,
    input  logic [CODE_W-1:0] tbl_data,
    output logic              code_vld,
    output logic [CODE_W-1:0] code,
    output logic              code_pot
);
    // gap counters: [0] first gap (any spike restarts), [1] post-to-post
    logic [1:0]       clr_v;
    logic [CNT_W-1:0] cnt_v [2];
    logic [CNT_W-1:0] cnt1, cnt2;

    assign clr_v = {post_spk, pre_spk | post_spk};

    for (genvar g = 0; g < 2; g++) begin : g_cnt
        sic_sat_counter #(.W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr_v[g]),
            .tick (tick),
            .cnt  (cnt_v[g])
        );
    end

    assign cnt1 = cnt_v[0];
    assign cnt2 = cnt_v[1];

    logic [Q1_W-1:0] q1_bin;
    logic [Q2_W-1:0] q2_bin;

    sic_quant #(.IN_W(CNT_W), .SHIFT(Q1_SHIFT), .OUT_W(Q1_W)) u_q1 (
        .val(cnt1), .bin(q1_bin)
    );
    sic_quant #(.IN_W(CNT_W), .SHIFT(Q2_SHIFT), .OUT_W(Q2_W)) u_q2 (
        .val(cnt2), .bin(q2_bin)
    );

    sic_state_e st, st_nxt;
    sic_q2sel_e q2sel;
    logic fire, pot, zero1;

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        fire   = 1'b0;
        pot    = 1'b0;
        zero1  = 1'b0;
        q2sel  = Q2_ZERO;
        unique case (st)
            ST_IDLE: begin
                if (pre_spk && post_spk) begin
                    fire  = 1'b1;
                    pot   = 1'b1;
                    zero1 = 1'b1;
                    q2sel = trip_mode ? Q2_LAST : Q2_ZERO;
                end else if (pre_spk) begin
                    st_nxt = ST_PRE;
                end else if (post_spk) begin
                    st_nxt = ST_POST;
                end
            end
            ST_PRE: begin
                if (post_spk) begin
                    fire   = 1'b1;
                    pot    = 1'b1;
                    zero1  = pre_spk;
                    q2sel  = trip_mode ? Q2_LAST : Q2_ZERO;
                    st_nxt = ST_IDLE;
                end
            end
            ST_POST: begin
                if (pre_spk && post_spk) begin
                    fire   = 1'b1;
                    pot    = 1'b1;
                    zero1  = 1'b1;
                    q2sel  = trip_mode ? Q2_MEAS : Q2_ZERO;
                    st_nxt = ST_IDLE;
                end else if (pre_spk) begin
                    fire   = 1'b1;
                    st_nxt = trip_mode ? ST_TRIP : ST_IDLE;
                end
            end
            ST_TRIP: begin
                if (post_spk) begin
                    fire   = 1'b1;
                    pot    = 1'b1;
                    zero1  = pre_spk;
                    q2sel  = Q2_MEAS;
                    st_nxt = ST_IDLE;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    logic [Q1_W-1:0]   idx_q1;
    logic [Q2_W-1:0]   idx_q2;
    logic [IDX_W-1:0]  rd_idx;
    logic [CODE_W-1:0] rd_code;

    assign idx_q1 = zero1 ? '0 : q1_bin;
    always_comb begin
        unique case (q2sel)
            Q2_MEAS: idx_q2 = q2_bin;
            Q2_LAST: idx_q2 = '1;
            default: idx_q2 = '0;
        endcase
    end
    assign rd_idx = {~pot, idx_q1, idx_q2};

    sic_code_table #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_tbl (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (tbl_we),
        .waddr(tbl_addr),
        .wdata(tbl_data),
        .raddr(rd_idx),
        .rdata(rd_code)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_vld <= 1'b0;
            code     <= '0;
            code_pot <= 1'b0;
        end else begin
            code_vld <= fire;
            code     <= fire ? rd_code : '0;
            code_pot <= fire & pot;
        end
    end
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             pre_spk,
    input logic             post_spk,
    input logic             code_vld,
    input logic             code_pot,
    input logic [CNT_W-1:0] cnt1,
    input logic [CNT_W-1:0] cnt2
);
    localparam logic [CNT_W-1:0] TOP = '1;

    assert_dep_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && !code_pot) |-> ($past(pre_spk) && !$past(post_spk)));

    assert_pot_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && code_pot) |-> $past(post_spk));

    assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_spk && !post_spk) |=> !code_vld);

    assert_coincident_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_spk && post_spk) |=> (code_vld && code_pot));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt1 == TOP && !pre_spk && !post_spk) |=> (cnt1 == TOP));

    assert_no_overflow2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt2 == TOP && !post_spk) |=> (cnt2 == TOP));

    assert_tick_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !pre_spk && !post_spk) |=> $stable(cnt1));
endmodule

bind spike_interval_coder sic_checker #(.CNT_W(CNT_W)) u_sic_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .pre_spk (pre_spk),
    .post_spk(post_spk),
    .code_vld(code_vld),
    .code_pot(code_pot),
    .cnt1    (cnt1),
    .cnt2    (cnt2)
);

// File: tb/tb_spike_interval_coder.sv
`timescale 1ns/1ps
module tb_spike_interval_coder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       pre_spk = 1'b0;
    logic       post_spk = 1'b0;
    logic       trip_mode = 1'b0;
    logic       tbl_we = 1'b0;
    logic [6:0] tbl_addr = '0;
    logic [5:0] tbl_data = '0;
    logic       code_vld;
    logic [5:0] code;
    logic       code_pot;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    spike_interval_coder dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pre_spk(pre_spk),
        .post_spk(post_spk), .trip_mode(trip_mode), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data), .code_vld(code_vld),
        .code(code), .code_pot(code_pot)
    );

    function automatic logic [5:0] fmap(input int a);
        return 6'((a * 37 + 11) % 64);
    endfunction

    // all drive tasks start and end at a falling edge
    task automatic spike(input bit p, input bit q);
        pre_spk  = p;
        post_spk = q;
        @(negedge clk);
        pre_spk  = 1'b0;
        post_spk = 1'b0;
    endtask

    task automatic idle(input int m);
        repeat (m) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [5:0] d);
        tbl_we   = 1'b1;
        tbl_addr = 7'(a);
        tbl_data = d;
        @(negedge clk);
        tbl_we   = 1'b0;
    endtask

    task automatic check_evt(input string req, input bit exp_pot, input logic [5:0] exp_code);
        n_chk++;
        if (code_vld !== 1'b1 || code_pot !== exp_pot || code !== exp_code) begin
            n_bad++;
            $display("FAIL %s: vld/pot/code = %0b/%0b/%0d, expected 1/%0b/%0d",
                     req, code_vld, code_pot, code, exp_pot, exp_code);
        end
    endtask

    task automatic check_none(input string req);
        n_chk++;
        if (code_vld !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: code_vld = %0b, expected 0", req, code_vld);
        end
    endtask

    task automatic t_reset;  // R1
        n_chk++;
        if (code_vld !== 1'b0 || code !== 6'd0) begin
            n_bad++;
            $display("FAIL R1 reset: vld/code = %0b/%0d, expected 0/0", code_vld, code);
        end
        trip_mode = 1'b0;
        spike(1, 0); idle(5); spike(0, 1);
        check_evt("R1 empty table", 1'b1, 6'd0);
    endtask

    task automatic t_program;
        for (int a = 0; a < 128; a++) wr(a, fmap(a));
    endtask

    task automatic t_pair_pot;  // R2, R6
        trip_mode = 1'b0;
        spike(1, 0); idle(9); spike(0, 1);
        check_evt("R2 pair pot gap9", 1'b1, fmap(8));
        idle(1); check_none("R10 one-cycle strobe");
        spike(1, 0); idle(40); spike(0, 1);
        check_evt("R6 pair pot gap40", 1'b1, fmap(40));
    endtask

    task automatic t_pair_dep;  // R3
        trip_mode = 1'b0;
        spike(0, 1); idle(13); spike(1, 0);
        check_evt("R3 pair dep gap13", 1'b0, fmap(76));
        idle(2); spike(0, 1);
        check_none("R3 pair mode re-armed, no triplet");
        idle(2); spike(1, 0);
        check_evt("R3 pair dep gap2", 1'b0, fmap(64));
    endtask

    task automatic t_triplet;  // R4, R6
        trip_mode = 1'b1;
        spike(0, 1); idle(20); spike(1, 0);
        check_evt("R4 triplet dep leg", 1'b0, fmap(84));
        idle(6); spike(0, 1);
        check_evt("R4 triplet pot short", 1'b1, fmap(4));
        spike(0, 1); idle(99); spike(1, 0);
        check_evt("R6 triplet dep clipped bin", 1'b0, fmap(124));
        idle(30); spike(0, 1);
        check_evt("R4 triplet pot long", 1'b1, fmap(30));
        spike(1, 0); idle(9); spike(0, 1);
        check_evt("R2 triplet pre-first last post bin", 1'b1, fmap(11));
    endtask

    task automatic t_coincident;  // R8
        trip_mode = 1'b0;
        spike(1, 1);
        check_evt("R8 idle coincident", 1'b1, fmap(0));
        trip_mode = 1'b1;
        spike(0, 1); idle(70); spike(1, 1);
        check_evt("R8 triplet coincident", 1'b1, fmap(1));
    endtask

    task automatic t_restart;  // R9
        trip_mode = 1'b0;
        spike(1, 0); idle(30); spike(1, 0); idle(12); spike(0, 1);
        check_evt("R9 latest pre timed", 1'b1, fmap(12));
    endtask

    task automatic t_tick;  // R5
        trip_mode = 1'b0;
        spike(1, 0); idle(8);
        tick = 1'b0; idle(12); tick = 1'b1;
        spike(0, 1);
        check_evt("R5 tick gating", 1'b1, fmap(8));
    endtask

    task automatic t_sat;  // R7
        trip_mode = 1'b1;
        spike(0, 1); idle(1100); spike(1, 0);
        check_evt("R7 saturated first gap", 1'b0, fmap(124));
        idle(2); spike(0, 1);
        check_evt("R7 saturated post gap", 1'b1, fmap(3));
    endtask

    task automatic t_quiet;  // R11
        for (int i = 0; i < 5; i++) begin
            idle(1);
            check_none("R11 no spike no strobe");
        end
    endtask

    task automatic t_rewrite;  // R10
        trip_mode = 1'b0;
        wr(8, 6'd63);
        spike(1, 0); idle(9); spike(0, 1);
        check_evt("R10 rewritten entry", 1'b1, 6'd63);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_pair_pot();
        t_pair_dep();
        t_triplet();
        t_coincident();
        t_restart();
        t_tick();
        t_sat();
        t_quiet();
        t_rewrite();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule